// File: doc/BRIEF.md
# MDIO Indirect-Access Management Slave

This block is the serial management slave that sits between a station manager and a local register file. It runs in the MDC clock domain. The MDIO input is sampled on each rising MDC edge. The slave looks for a synchronisation run of ones followed by a start code. It then decodes the operation, port and device fields. It finishes with a turnaround and a 16-bit payload. Addressing is indirect: one frame loads a register address for a device, and later frames read or write at that held address. A read variant also advances the held address once the frame completes.

Each supported device keeps its own held address. Toward the register file the slave issues one-cycle read and write strobes, with the device ID, the held address and the write data. Read data comes back combinationally in the strobe cycle and is shifted out on MDIO. The output enable is high only while the slave owns the line.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive sampled ones followed by two zero bits. With 31 ones before the zeros, the frame is ignored.
- R2: The 5-bit port field, the third to seventh bits after the start code, is sent MSB first. If it differs from `port_addr`, the frame causes no strobe and no MDIO drive.
- R3: The 5-bit device field follows the port field. Only 1, 3 and 4 are accepted. Any other value leaves the frame unanswered and changes nothing.
- R4: Operation 00 (the first two bits after the start code) loads the 16-bit payload, MSB first, into the held address of the addressed device.
- R5: Operation 01 pulses `reg_wr` for exactly one cycle, after the edge that samples the last payload bit. The pulse carries the device ID, the held address and the payload. `reg_rd` and `reg_wr` are never high together.
- R6: Operations 11 and 10 pulse `reg_rd` for one cycle after the last device bit, with the device ID and held address. During the first turnaround bit `mdio_oe` stays low. For the second turnaround bit it is high with `mdio_o` at 0. The 16 bits of `reg_rdata` then follow MSB first, each updated after a rising MDC edge.
- R7: Operation 10 increments the held address after the frame, wrapping from 0xFFFF to 0x0000.
- R8: Operations 11 and 01 leave the held address unchanged.
- R9: Each of the three devices has an independent held address.
- R10: In an address or write frame, a turnaround other than 1 then 0 discards the frame. There is no write and no held-address change.
- R11: `mdio_oe` is high for exactly 17 consecutive cycles per accepted read frame, and never otherwise.
- R12: After synchronous reset all held addresses are 0, and `mdio_oe`, `reg_rd` and `reg_wr` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mdio_i | input | 1 | Sampled MDIO line |
| port_addr | input | 5 | Strapped port address |
| mdio_o | output | 1 | MDIO drive value |
| mdio_oe | output | 1 | MDIO driver enable |
| reg_dev | output | 5 | Device ID of the current access |
| reg_addr | output | 16 | Register address of the current access |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Read data returned in the strobe cycle |

## Verification
The bench targets several edge cases of the increment. It wraps a held address from 0xFFFF to 0x0000; a design that carried into a wider register would return 0x10000 truncated wrongly or stick. It repeats plain reads to show they do not advance. It interleaves devices, which catches a single shared address register. It probes a preamble one bit short and a malformed turnaround. A design that counted preamble ones loosely, or skipped the turnaround check, would commit a bogus address or write. It also counts driven cycles and the zero turnaround bit, which exposes a driver that is late, early or left on.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;
  typedef enum logic [2:0] {S_HUNT, S_START, S_HDR, S_TURN, S_DATA} rx_state_t;
  localparam logic [1:0] OP_ADDR     = 2'b00;
  localparam logic [1:0] OP_WRITE    = 2'b01;
  localparam logic [1:0] OP_READ     = 2'b11;
  localparam logic [1:0] OP_READ_INC = 2'b10;
  localparam int PRE_ONES = 32;
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_slv_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PAW  = 5,
  parameter int DEVW = 5,
  parameter int NDEV = 3,
  parameter int IDXW = 2,
  parameter logic [NDEV*DEVW-1:0] DEV_IDS = {5'd4, 5'd3, 5'd1}
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  input  logic [PAW-1:0]  port_addr,
  output logic            hit,
  output logic [1:0]      hit_op,
  output logic [IDXW-1:0] hit_idx,
  output logic            fin,
  output logic [1:0]      fin_op,
  output logic [IDXW-1:0] fin_idx,
  output logic [DW-1:0]   fin_data
);
  localparam int HDR_BITS = 2 + PAW + DEVW;
  localparam int CW = $clog2(DW);
  localparam int OW = $clog2(PRE_ONES + 1);

  rx_state_t            st;
  logic [OW-1:0]        ones;
  logic [CW-1:0]        cnt;
  logic [HDR_BITS-2:0]  hdr_q;
  logic [DW-2:0]        dsh;
  logic [HDR_BITS-1:0]  hdr_w;
  logic                 dev_ok;
  logic                 match;

  assign hdr_w    = {hdr_q, din};
  assign hit_op   = hdr_w[HDR_BITS-1 -: 2];
  assign fin_data = {dsh, din};

  always_comb begin
    dev_ok  = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NDEV; i++) begin
      if (hdr_w[DEVW-1:0] == DEV_IDS[i*DEVW +: DEVW]) begin
        dev_ok  = 1'b1;
        hit_idx = IDXW'(i);
      end
    end
  end

  assign match = dev_ok && (hdr_w[DEVW +: PAW] == port_addr);
  assign hit   = (st == S_HDR) && (cnt == CW'(HDR_BITS - 1)) && match;
  assign fin   = (st == S_DATA) && (cnt == CW'(DW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_HUNT;
      ones   <= '0;
      cnt    <= '0;
      hdr_q  <= '0;
      dsh    <= '0;
      fin_op <= '0;
      fin_idx <= '0;
    end else begin
      case (st)
        S_HUNT: begin
          if (din) begin
            if (ones != OW'(PRE_ONES)) ones <= ones + 1'b1;
          end else begin
            if (ones == OW'(PRE_ONES)) st <= S_START;
            ones <= '0;
          end
        end
        S_START: begin
          if (!din) begin
            st  <= S_HDR;
            cnt <= '0;
          end else begin
            st   <= S_HUNT;
            ones <= OW'(1);
          end
        end
        S_HDR: begin
          hdr_q <= hdr_w[HDR_BITS-2:0];
          cnt   <= cnt + 1'b1;
          if (cnt == CW'(HDR_BITS - 1)) begin
            cnt <= '0;
            if (match) begin
              st      <= S_TURN;
              fin_op  <= hit_op;
              fin_idx <= hit_idx;
            end else begin
              st <= S_HUNT;
            end
          end
        end
        S_TURN: begin
          if (cnt == '0) begin
            cnt <= cnt + 1'b1;
            if (!fin_op[1] && !din) st <= S_HUNT;
          end else begin
            cnt <= '0;
            if (!fin_op[1] && din) st <= S_HUNT;
            else                   st <= S_DATA;
          end
        end
        S_DATA: begin
          dsh <= fin_data[DW-2:0];
          cnt <= cnt + 1'b1;
          if (cnt == CW'(DW - 1)) begin
            st  <= S_HUNT;
            cnt <= '0;
          end
        end
        default: st <= S_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/mdio_addr_bank.sv
module mdio_addr_bank #(
  parameter int DW   = 16,
  parameter int NDEV = 3,
  parameter int IDXW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ld,
  input  logic               inc,
  input  logic [IDXW-1:0]    idx,
  input  logic [DW-1:0]      val,
  output logic [NDEV*DW-1:0] held_flat
);
  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    logic [DW-1:0] held_q;
    always_ff @(posedge clk) begin
      if (rst)                            held_q <= '0;
      else if (ld  && idx == IDXW'(g))    held_q <= val;
      else if (inc && idx == IDXW'(g))    held_q <= held_q + 1'b1;
    end
    assign held_flat[g*DW +: DW] = held_q;
  end
endmodule

// File: rtl/mdio_rd_drv.sv
module mdio_rd_drv #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] word,
  output logic          mdo,
  output logic          mdoe
);
  localparam int KW = $clog2(DW + 1);

  logic [DW-1:0] sh;
  logic [KW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      left <= '0;
      mdo  <= 1'b0;
      mdoe <= 1'b0;
    end else if (load) begin
      sh   <= word;
      left <= KW'(DW);
      mdo  <= 1'b0;
      mdoe <= 1'b1;
    end else if (left != '0) begin
      mdo  <= sh[DW-1];
      sh   <= {sh[DW-2:0], 1'b0};
      left <= left - 1'b1;
    end else begin
      mdo  <= 1'b0;
      mdoe <= 1'b0;
    end
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PAW  = 5,
  parameter int DEVW = 5,
  parameter int NDEV = 3,
  parameter logic [NDEV*DEVW-1:0] DEV_IDS = {5'd4, 5'd3, 5'd1}
) (
  input  logic            mdc,
  input  logic            rst,
  input  logic            mdio_i,
  input  logic [PAW-1:0]  port_addr,
  output logic            mdio_o,
  output logic            mdio_oe,
  output logic [DEVW-1:0] reg_dev,
  output logic [DW-1:0]   reg_addr,
  output logic            reg_wr,
  output logic [DW-1:0]   reg_wdata,
  output logic            reg_rd,
  input  logic [DW-1:0]   reg_rdata
);
  localparam int IDXW = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic               hit, fin;
  logic [1:0]         hit_op, fin_op;
  logic [IDXW-1:0]    hit_idx, fin_idx;
  logic [DW-1:0]      fin_data;
  logic [NDEV*DW-1:0] held_flat;

  mdio_frame_rx #(
    .DW(DW), .PAW(PAW), .DEVW(DEVW), .NDEV(NDEV), .IDXW(IDXW), .DEV_IDS(DEV_IDS)
  ) u_rx (
    .clk(mdc), .rst(rst), .din(mdio_i), .port_addr(port_addr),
    .hit(hit), .hit_op(hit_op), .hit_idx(hit_idx),
    .fin(fin), .fin_op(fin_op), .fin_idx(fin_idx), .fin_data(fin_data)
  );

  mdio_addr_bank #(.DW(DW), .NDEV(NDEV), .IDXW(IDXW)) u_bank (
    .clk(mdc), .rst(rst),
    .ld(fin && fin_op == OP_ADDR),
    .inc(fin && fin_op == OP_READ_INC),
    .idx(fin_idx), .val(fin_data), .held_flat(held_flat)
  );

  mdio_rd_drv #(.DW(DW)) u_drv (
    .clk(mdc), .rst(rst), .load(reg_rd), .word(reg_rdata),
    .mdo(mdio_o), .mdoe(mdio_oe)
  );

  always_ff @(posedge mdc) begin
    if (rst) begin
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_dev   <= '0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_rd <= 1'b0;
      reg_wr <= 1'b0;
      if (hit && hit_op[1]) begin
        reg_rd   <= 1'b1;
        reg_dev  <= DEV_IDS[hit_idx*DEVW +: DEVW];
        reg_addr <= held_flat[hit_idx*DW +: DW];
      end else if (fin && fin_op == OP_WRITE) begin
        reg_wr    <= 1'b1;
        reg_dev   <= DEV_IDS[fin_idx*DEVW +: DEVW];
        reg_addr  <= held_flat[fin_idx*DW +: DW];
        reg_wdata <= fin_data;
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int DW = 16
) (
  input logic mdc,
  input logic rst,
  input logic mdio_o,
  input logic mdio_oe,
  input logic reg_rd,
  input logic reg_wr
);
  logic [5:0] oe_run;

  always_ff @(posedge mdc) begin
    if (rst)           oe_run <= '0;
    else if (mdio_oe)  oe_run <= (oe_run == 6'h3F) ? oe_run : oe_run + 1'b1;
    else               oe_run <= '0;
  end

  // R6
  turn_zero_chk: assert property (@(posedge mdc) disable iff (rst)
    $rose(mdio_oe) |-> !mdio_o);

  // R6
  rd_then_drive_chk: assert property (@(posedge mdc) disable iff (rst)
    reg_rd |=> mdio_oe);

  // R11
  drive_needs_rd_chk: assert property (@(posedge mdc) disable iff (rst)
    $rose(mdio_oe) |-> $past(reg_rd));

  // R11
  drive_span_chk: assert property (@(posedge mdc) disable iff (rst)
    oe_run <= 6'(DW + 1));

  // R5
  wr_pulse_chk: assert property (@(posedge mdc) disable iff (rst)
    reg_wr |=> !reg_wr);

  // R5
  strobe_excl_chk: assert property (@(posedge mdc) disable iff (rst)
    !(reg_rd && reg_wr));
endmodule

bind mdio_mgmt_slave mdio_mgmt_chk #(.DW(DW)) u_chk (
  .mdc(mdc), .rst(rst), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/mdio_mgmt_slave_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_bench;
  localparam logic [4:0] PORT = 5'h0B;
  localparam int NV = 16;

  logic        mdc = 1'b0;
  logic        rst = 1'b1;
  logic        mdio_i = 1'b1;
  logic        mdio_o, mdio_oe, reg_wr, reg_rd;
  logic [4:0]  reg_dev;
  logic [15:0] reg_addr, reg_wdata, reg_rdata;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, oe_cnt = 0;
  logic [4:0]  wr_dev;
  logic [15:0] wr_addr, wr_data;
  logic [15:0] m_held [3];

  always #5 mdc = ~mdc;

  function automatic logic [15:0] rfun(logic [4:0] d, logic [15:0] a);
    return (a ^ 16'h5A3C) + {11'd0, d};
  endfunction

  function automatic int didx(logic [4:0] d);
    case (d)
      5'd1: return 0;
      5'd3: return 1;
      5'd4: return 2;
      default: return -1;
    endcase
  endfunction

  assign reg_rdata = rfun(reg_dev, reg_addr);

  mdio_mgmt_slave u_mdio_mgmt_slave (
    .mdc(mdc), .rst(rst), .mdio_i(mdio_i), .port_addr(PORT),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .reg_dev(reg_dev), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  always @(negedge mdc) begin
    if (!rst) begin
      if (reg_rd) rd_cnt++;
      if (mdio_oe) oe_cnt++;
      if (reg_wr) begin
        wr_cnt++;
        wr_dev  = reg_dev;
        wr_addr = reg_addr;
        wr_data = reg_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    @(negedge mdc);
    mdio_i = b;
  endtask

  task automatic run_frame(input logic [1:0] op, input logic [4:0] prt, input logic [4:0] dev,
                           input logic [15:0] dat, input logic [1:0] ta, input int pre,
                           output logic [15:0] rv, output bit ta_ok);
    rv = '0;
    ta_ok = 1'b1;
    bit_out(1'b0);
    for (int i = 0; i < pre; i++) bit_out(1'b1);
    bit_out(1'b0); bit_out(1'b0);
    for (int i = 1; i >= 0; i--) bit_out(op[i]);
    for (int i = 4; i >= 0; i--) bit_out(prt[i]);
    for (int i = 4; i >= 0; i--) bit_out(dev[i]);
    if (op[1]) begin
      bit_out(1'b1);
      if (mdio_oe !== 1'b0) ta_ok = 1'b0;
      bit_out(1'b1);
      if (mdio_oe !== 1'b1 || mdio_o !== 1'b0) ta_ok = 1'b0;
      for (int k = 15; k >= 0; k--) begin
        bit_out(1'b1);
        rv[k] = mdio_o;
      end
    end else begin
      bit_out(ta[1]); bit_out(ta[0]);
      for (int k = 15; k >= 0; k--) bit_out(dat[k]);
    end
    bit_out(1'b1);
    bit_out(1'b1);
    bit_out(1'b1);
  endtask

  localparam logic [27:0] VEC [NV] = '{
    {2'b00, 5'h0B, 5'd1, 16'h1234},
    {2'b01, 5'h0B, 5'd1, 16'hBEEF},
    {2'b11, 5'h0B, 5'd1, 16'h0000},
    {2'b11, 5'h0B, 5'd1, 16'h0000},
    {2'b10, 5'h0B, 5'd1, 16'h0000},
    {2'b11, 5'h0B, 5'd1, 16'h0000},
    {2'b00, 5'h0B, 5'd3, 16'hFFFF},
    {2'b10, 5'h0B, 5'd3, 16'h0000},
    {2'b11, 5'h0B, 5'd3, 16'h0000},
    {2'b00, 5'h0B, 5'd4, 16'h0042},
    {2'b11, 5'h0B, 5'd4, 16'h0000},
    {2'b11, 5'h0B, 5'd1, 16'h0000},
    {2'b00, 5'h0B, 5'd2, 16'h7070},
    {2'b11, 5'h0B, 5'd5, 16'h0000},
    {2'b00, 5'h0A, 5'd1, 16'h0000},
    {2'b11, 5'h1B, 5'd1, 16'h0000}
  };

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rv;
    bit          tok;
    int          r0, w0, o0, di;
    logic [1:0]  op;
    logic [4:0]  prt, dev;
    logic [15:0] dat;

    for (int i = 0; i < 3; i++) m_held[i] = 16'h0000;
    repeat (4) @(posedge mdc);
    @(negedge mdc);
    rst = 1'b0;
    // R12: outputs idle after reset
    chk(!mdio_oe && !reg_rd && !reg_wr, "R12", {29'd0, mdio_oe, reg_rd, reg_wr}, 0);

    // R12: held address of device 3 starts at zero
    run_frame(2'b11, PORT, 5'd3, 16'h0, 2'b10, 32, rv, tok);
    chk(rv == rfun(5'd3, 16'h0000), "R12", rv, rfun(5'd3, 16'h0000));

    for (int i = 0; i < NV; i++) begin
      op  = VEC[i][27:26];
      prt = VEC[i][25:21];
      dev = VEC[i][20:16];
      dat = VEC[i][15:0];
      di  = didx(dev);
      r0 = rd_cnt; w0 = wr_cnt; o0 = oe_cnt;
      run_frame(op, prt, dev, dat, 2'b10, 32, rv, tok);
      if (prt != PORT) begin
        // R2: foreign port ignored
        chk(rd_cnt == r0 && wr_cnt == w0 && oe_cnt == o0, "R2", oe_cnt - o0, 0);
      end else if (di < 0) begin
        // R3: unsupported device ignored
        chk(rd_cnt == r0 && wr_cnt == w0 && oe_cnt == o0, "R3", oe_cnt - o0, 0);
      end else begin
        case (op)
          2'b00: begin
            m_held[di] = dat;
            chk(rd_cnt == r0 && wr_cnt == w0, "R4", wr_cnt - w0, 0);
          end
          2'b01: begin
            chk(wr_cnt == w0 + 1, "R5", wr_cnt - w0, 1);
            chk(wr_dev == dev && wr_addr == m_held[di] && wr_data == dat, "R5",
                {wr_addr, wr_data}, {m_held[di], dat});
          end
          default: begin
            // R6 / R8 / R9: data read at held address of this device
            chk(rv == rfun(dev, m_held[di]), op == 2'b10 ? "R7" : "R8", rv, rfun(dev, m_held[di]));
            chk(tok, "R6", 0, 1);
            chk(rd_cnt == r0 + 1, "R6", rd_cnt - r0, 1);
            chk(oe_cnt == o0 + 17, "R11", oe_cnt - o0, 17);
            if (op == 2'b10) m_held[di] = m_held[di] + 16'd1;
          end
        endcase
      end
    end

    // R9: device 1 kept its own address after activity on devices 3 and 4
    run_frame(2'b11, PORT, 5'd1, 16'h0, 2'b10, 32, rv, tok);
    chk(rv == rfun(5'd1, 16'h1235), "R9", rv, rfun(5'd1, 16'h1235));

    // R10: bad turnaround on a write frame
    w0 = wr_cnt;
    run_frame(2'b01, PORT, 5'd1, 16'h0F0F, 2'b11, 32, rv, tok);
    chk(wr_cnt == w0, "R10", wr_cnt - w0, 0);

    // R10: bad turnaround on an address frame
    run_frame(2'b00, PORT, 5'd4, 16'h0F0F, 2'b00, 32, rv, tok);
    run_frame(2'b11, PORT, 5'd4, 16'h0, 2'b10, 32, rv, tok);
    chk(rv == rfun(5'd4, 16'h0042), "R10", rv, rfun(5'd4, 16'h0042));

    // R1: 31-one preamble ignored
    run_frame(2'b00, PORT, 5'd4, 16'h0101, 2'b10, 31, rv, tok);
    run_frame(2'b11, PORT, 5'd4, 16'h0, 2'b10, 32, rv, tok);
    chk(rv == rfun(5'd4, 16'h0042), "R1", rv, rfun(5'd4, 16'h0042));

    // R1: longer preamble accepted
    run_frame(2'b00, PORT, 5'd4, 16'h0303, 2'b10, 40, rv, tok);
    run_frame(2'b11, PORT, 5'd4, 16'h0, 2'b10, 32, rv, tok);
    chk(rv == rfun(5'd4, 16'h0303), "R1", rv, rfun(5'd4, 16'h0303));

    // R11: driver idle between frames
    o0 = oe_cnt;
    repeat (20) @(negedge mdc);
    chk(oe_cnt == o0, "R11", oe_cnt - o0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule